// File: doc/BRIEF.md
# Wake-Capable Port Edge Interrupt Controller

This block watches a port of general-purpose input pins and turns selected signal edges into latched interrupt flags. Each pin has an enable bit and a polarity bit that chooses rising or falling detection. A pin's input is first passed through a short synchronizer chain. An edge is then recognised by comparing two synchronized samples taken on consecutive clock edges. A recognised edge on an enabled pin sets that pin's flag. The single interrupt output is asserted while any enabled pin holds a set flag. Software removes flags by writing ones to the flag-clear address.

The block also serves a clock controller that may have stopped the system clock entirely. A wake request is formed without any clock. It is the OR, over the enabled pins, of "pin now sits at its active level and the pin is armed". A pin becomes armed once its synchronized sample has been seen at the idle level. The clock controller restarts the clock and raises a ready input. The next cycles of the restarted clock sample the pin and latch its flag. The wake request then drops.

Top module: `pe_wake_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every flag, every enable bit and every edge-select bit is 0, and the interrupt and wake-request outputs are low while the pins are low.
- R2: With edge-select 0, an enabled pin sampled low on one clock edge and high on the next sets its flag. A pin change driven between clock edges shows on `flags_out` after the third following rising clock edge, that is SYNC_STAGES+1 edges, and not before.
- R3: With edge-select 1, the same holds for a high-to-low transition.
- R4: Detection is edge sensitive. A pin held at its active level after its flag has been cleared does not set the flag again.
- R5: A write to address 2 clears exactly the flag bits written as one and leaves all other flags unchanged. Address 0 holds the enable bits and address 1 holds the edge-select bits.
- R6: When an edge is detected in the same cycle as a clear of that pin's flag, the flag stays set.
- R7: `irq_out` is high exactly when some pin has both its flag and its enable set. Clearing the enable masks the interrupt but keeps the flag.
- R8: A pin whose enable bit is 0 never sets its flag and never raises the wake request.
- R9: An enabled, armed pin that moves to its active level raises `wake_req` through combinational logic, with no clock edge needed. The request is low while every enabled pin is at its idle level.
- R10: The wake request stays high while `clk_ready` is low. It falls on the first rising clock edge at which `clk_ready` is high and the waking pin's flag is set.
- R11: A pin pulse that lasts one full clock period is captured in its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; may be stopped by the clock controller |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_in | input | NUM_PINS | Asynchronous port pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 enable, 1 edge select, 2 flag clear (write one to clear) |
| wr_data | input | NUM_PINS | Register write data |
| clk_ready | input | 1 | Clock controller reports a stable running clock |
| flags_out | output | NUM_PINS | Latched per-pin edge flags |
| irq_out | output | 1 | OR of flag AND enable over all pins |
| wake_req | output | 1 | Clock-free wake request to the clock controller |

## Verification
The bench builds the block with its defaults: eight pins and a two-stage synchronizer. These values are small enough that every pin is swept in both edge polarities. In each pass the other seven pins toggle while disabled. With a two-stage chain the flag latency is exactly three edges, so the bench checks the cycle before capture as well as the cycle of capture. The bench can also halt its clock, which puts the clock-free wake path and the ready handshake within reach.

// File: rtl/pe_pkg.sv
// Package: shared register addressing for the port edge interrupt controller.
// Assumes a two-bit write address; unused codes are ignored.
package pe_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_ENABLE   = 2'd0,
        REG_EDGE_SEL = 2'd1,
        REG_FLAG_CLR = 2'd2
    } reg_sel_e;
endpackage

// File: rtl/pe_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes STAGES >= 2 and that each bit is independent (no bus coherence).
module pe_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        if (k == 0) begin : g_first
            // Capture the raw pin levels into the first stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[k] <= '0;
                else        stg[k] <= din;
            end
        end else begin : g_next
            // Shift the previous stage forward to settle metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[k] <= '0;
                else        stg[k] <= stg[k-1];
            end
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/pe_edge_det.sv
// Module: per-pin edge detector and clock-free wake term.
// Compares the synchronized sample with the one from the previous edge.
// Assumes pin_async is the raw pin and pin_sync is its synchronized copy.
// The wake term uses the raw pin, so it works while clk is stopped.
module pe_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    input  logic pin_sync,
    input  logic enable,
    input  logic fall_sel,
    input  logic clk_ready,
    input  logic flag_q,
    output logic edge_hit,
    output logic wake_bit
);
    logic prev_q;
    logic armed_q;
    logic active_sync;
    logic active_async;

    // Hold the sample from the previous clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pin_sync;
    end

    // Map the sample to "at active level" for the chosen polarity.
    always_comb begin
        active_sync  = fall_sel ? ~pin_sync  : pin_sync;
        active_async = fall_sel ? ~pin_async : pin_async;
    end

    // Detect the selected transition between two consecutive samples.
    always_comb begin
        if (fall_sel) edge_hit = enable & prev_q & ~pin_sync;
        else          edge_hit = enable & ~prev_q & pin_sync;
    end

    // Arm on an idle-level sample; disarm once ready and the flag is captured.
    always_ff @(posedge clk) begin
        if (!rst_n)                 armed_q <= 1'b0;
        else if (!active_sync)      armed_q <= 1'b1;
        else if (flag_q && clk_ready) armed_q <= 1'b0;
    end

    // Clock-free wake term: enabled, armed and now at the active level.
    assign wake_bit = enable & armed_q & active_async;

    AST_WAKE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && clk_ready && active_sync) |=> !wake_bit); // R10
endmodule

// File: rtl/pe_flags.sv
// Module: per-pin flag register with write-one-to-clear and interrupt OR.
// A set request in the same cycle as a clear keeps the flag set.
// Assumes set_vec is already qualified by the pin enables.
module pe_flags #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_vec,
    input  logic [WIDTH-1:0] clr_vec,
    input  logic [WIDTH-1:0] en_vec,
    output logic [WIDTH-1:0] flag_q,
    output logic             irq
);
    // Apply clears first, then sets, so a new edge wins.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~clr_vec) | set_vec;
    end

    // Raise the interrupt while any enabled pin has a pending flag.
    assign irq = |(flag_q & en_vec);

    for (genvar i = 0; i < WIDTH; i++) begin : g_chk
        AST_FLAG_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_q[i]) |-> $past(set_vec[i])); // R2
        AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (set_vec[i] && clr_vec[i]) |=> flag_q[i]); // R6
        AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[i] && !set_vec[i]) |=> !flag_q[i]); // R5
    end
endmodule

// File: rtl/pe_wake_irq_ctrl.sv
// Module: top of the wake-capable port edge interrupt controller.
// Holds the enable and edge-select registers and decodes the clear write.
// Instantiates the synchronizer, the per-pin detectors and the flag bank.
// Assumes wake_req is consumed by a clock controller that drives clk_ready.
module pe_wake_irq_ctrl
    import pe_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [NUM_PINS-1:0] wr_data,
    input  logic                clk_ready,
    output logic [NUM_PINS-1:0] flags_out,
    output logic                irq_out,
    output logic                wake_req
);
    logic [NUM_PINS-1:0] en_q;
    logic [NUM_PINS-1:0] sel_q;
    logic [NUM_PINS-1:0] pin_s;
    logic [NUM_PINS-1:0] edge_vec;
    logic [NUM_PINS-1:0] wake_vec;
    logic [NUM_PINS-1:0] clr_vec;
    logic [NUM_PINS-1:0] flag_q;

    // Enable and edge-select register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            sel_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == REG_ENABLE)   en_q  <= wr_data;
            if (wr_addr == REG_EDGE_SEL) sel_q <= wr_data;
        end
    end

    // Decode the write-one-to-clear strobe for the flag bank.
    assign clr_vec = (wr_en && wr_addr == REG_FLAG_CLR) ? wr_data : '0;

    pe_sync #(
        .WIDTH (NUM_PINS),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .dout (pin_s)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        pe_edge_det u_det (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_async(pin_in[i]),
            .pin_sync (pin_s[i]),
            .enable   (en_q[i]),
            .fall_sel (sel_q[i]),
            .clk_ready(clk_ready),
            .flag_q   (flag_q[i]),
            .edge_hit (edge_vec[i]),
            .wake_bit (wake_vec[i])
        );

        AST_DISABLED_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_q[i]) |-> $past(en_q[i])); // R8
    end

    pe_flags #(
        .WIDTH(NUM_PINS)
    ) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_vec(edge_vec),
        .clr_vec(clr_vec),
        .en_vec (en_q),
        .flag_q (flag_q),
        .irq    (irq_out)
    );

    // Clock-free wake request: OR of the per-pin wake terms.
    assign wake_req  = |wake_vec;
    assign flags_out = flag_q;

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_out == '0) |-> !irq_out); // R7
endmodule

// File: tb/sim_pe_wake_irq_ctrl.sv
module sim_pe_wake_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         clk_run = 1'b1;
    logic         rst_n = 1'b0;
    logic [N-1:0] pins = '0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [N-1:0] wr_data = '0;
    logic         clk_ready = 1'b1;
    logic [N-1:0] flags_out;
    logic         irq_out;
    logic         wake_req;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    pe_wake_irq_ctrl #(.NUM_PINS(N), .SYNC_STAGES(2)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pins),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .clk_ready(clk_ready),
        .flags_out(flags_out),
        .irq_out  (irq_out),
        .wake_req (wake_req)
    );

    always begin
        #(CLK_PERIOD/2);
        if (clk_run) clk = ~clk;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(2);
        // R1: reset state
        chk(flags_out, 0, "R1 flags");
        chk(irq_out, 0, "R1 irq");
        chk(wake_req, 0, "R1 wake");

        // Sweep every pin in both polarities; the other pins toggle while disabled
        for (int i = 0; i < N; i++) begin
            for (int s = 0; s < 2; s++) begin
                logic [N-1:0] idle;
                logic [N-1:0] bit_i;
                string tg;
                idle  = (s == 1) ? '1 : '0;
                bit_i = N'(1) << i;
                tg    = (s == 1) ? "R3" : "R2";
                wr(0, '0);
                pins = idle;
                wr(1, idle);
                wr(0, bit_i);
                tick(4);
                wr(2, '1);
                tick(1);
                chk(flags_out, 0, "R8 pre-sweep flags");
                chk(wake_req, 0, "R9 idle wake");
                @(negedge clk);
                pins = ~idle;
                #1;
                chk(wake_req, 1, "R9 async wake");
                tick(2);
                chk(flags_out, 0, {tg, " not before latency"});
                tick(1);
                chk(flags_out, bit_i, {tg, " flag / R8 only enabled pin"});
                chk(irq_out, 1, "R7 irq on flag");
                chk(wake_req, 1, "R10 wake held until capture edge");
                tick(1);
                chk(wake_req, 0, "R10 wake released");
                wr(2, bit_i);
                tick(3);
                chk(flags_out, 0, "R4 held level no re-flag");
                chk(irq_out, 0, "R7 irq cleared");
                @(negedge clk);
                pins = idle;
            end
        end

        // R8: all pins disabled, all toggle
        wr(0, '0); wr(1, '0); pins = '0; tick(4); wr(2, '1);
        @(negedge clk); pins = '1; #1;
        chk(wake_req, 0, "R8 disabled no wake");
        tick(4);
        chk(flags_out, 0, "R8 disabled no flag");

        // R6: edge in same cycle as clear
        pins = '0; wr(0, 8'h01); tick(4); wr(2, '1);
        @(negedge clk); pins = 8'h01; tick(3);
        chk(flags_out, 8'h01, "R2 setup flag");
        @(negedge clk); pins = 8'h00; tick(4);
        chk(flags_out, 8'h01, "R3 falling ignored with rising select");
        @(negedge clk); pins = 8'h01;
        @(negedge clk);
        @(negedge clk); wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h01;
        @(negedge clk); wr_en = 1'b0;
        chk(flags_out, 8'h01, "R6 edge wins over clear");
        wr(2, 8'h01);
        chk(flags_out, 8'h00, "R5 clear without edge");

        // R5 selective clear, R7 masking
        wr(0, '1); pins = '0; tick(4); wr(2, '1);
        @(negedge clk); pins = 8'h05; tick(3);
        chk(flags_out, 8'h05, "R2 two pins");
        wr(2, 8'h01);
        chk(flags_out, 8'h04, "R5 selective clear");
        chk(irq_out, 1, "R7 irq pending");
        wr(0, 8'hFB);
        chk(irq_out, 0, "R7 masked irq");
        chk(flags_out, 8'h04, "R7 flag kept when masked");
        wr(0, '1);
        chk(irq_out, 1, "R7 unmasked irq");

        // R11: one-period pulse
        pins = '0; tick(4); wr(2, '1);
        @(negedge clk); pins = 8'h10;
        @(negedge clk); pins = 8'h00;
        tick(2);
        chk(flags_out, 8'h10, "R11 short pulse captured");

        // R9/R10: clock stopped, then restarted with late ready
        wr(0, 8'h01); pins = '0; tick(4); wr(2, '1); tick(1);
        clk_ready = 1'b0;
        clk_run = 1'b0;
        #(CLK_PERIOD * 3);
        pins = 8'h01;
        #(CLK_PERIOD * 3);
        chk(wake_req, 1, "R9 wake with clock stopped");
        chk(flags_out, 0, "R9 no flag without clock");
        clk_run = 1'b1;
        tick(4);
        chk(flags_out, 8'h01, "R9 flag after restart");
        chk(wake_req, 1, "R10 wake held while not ready");
        clk_ready = 1'b1;
        tick(1);
        chk(wake_req, 0, "R10 wake drops once ready");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule